// File: doc/BRIEF.md
# Periodic / One-Shot Comparator Timer Channel

This block is a single timer channel that watches a free-running 64-bit main counter supplied from outside. When the counter reaches the value held in the channel's comparator, the channel raises a one-cycle interrupt pulse. It also sets a sticky status flag. In one-shot mode the comparator stays where software put it. In periodic mode a hidden period register is added to the comparator after every match, so the pulses repeat at a fixed spacing.

Software reaches the channel through 32-bit reads and writes of four word slots. Address 0 is the low configuration word. Address 1 is the read-only upper configuration word, which holds a capability constant. Address 2 is the low comparator half and address 3 is the high comparator half. A system-wide enable input gates the whole channel. While that enable is low, nothing fires and the comparator does not move. When the enable returns, a periodic channel catches up its comparator to the resumed counter. An optional 32-bit mode confines both the comparison and the period arithmetic to the low 32 bits.

Top module: `tmr_channel`

## Requirements
- R1: After reset the comparator reads all ones and the low configuration word reads 0x0000_0010. Bit 4, periodic-capable, always reads 1. The interrupt and status outputs are low.
- R2: Writes to the low configuration word change only the bits in 0x0000_7F4E. Every other bit reads 0, except bit 4, which reads 1. Address 1 always reads the capability constant, and writes to address 1 change nothing.
- R3: The route output equals configuration bits [13:9].
- R4: A comparator write updates the half being written when the channel is in one-shot mode (bit 3 clear) or when set-value (bit 6) is armed. In periodic mode without set-value, the comparator is left unchanged.
- R5: In periodic mode (bit 3 set), a comparator write also loads the matching half of the period register. The period's top bit is forced to 0: bit 31 in 32-bit mode, bit 63 otherwise.
- R6: The set-value bit reads 0 after any write to either comparator half.
- R7: A match occurs when the counter equals the comparator while interrupt enable (bit 2) and the global enable are both high. A match drives the interrupt output high for exactly the following cycle and sets the status output.
- R8: In periodic mode with a nonzero period, the period is added to the comparator once per cycle while the comparator is not later than the counter. "Later" uses a wrap-aware signed difference. The first add happens on the match cycle itself.
- R9: Configuration bit 8 selects 32-bit mode. Setting it clears the upper halves of the comparator and the period. In 32-bit mode, matching uses only the low 32 bits, the period addition wraps at 32 bits, and writes to the high comparator half do not change the upper halves of the comparator or the period.
- R10: While the global enable is low, no pulse is produced and the comparator does not advance. Once the enable is high again, a periodic comparator that is not all ones is advanced past the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 64 | Main counter value |
| glb_en_i | input | 1 | Global enable |
| wr_en_i | input | 1 | Write strobe for one 32-bit word |
| addr_i | input | 2 | Word slot: 0 cfg low, 1 cfg high, 2 cmp low, 3 cmp high |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed slot (combinational) |
| irq_o | output | 1 | One-cycle interrupt pulse |
| stat_o | output | 1 | Sticky status, set on every pulse |
| route_o | output | 5 | Interrupt route field |

## Verification
The bench targets the following cases; each line says what a wrong design would do.

- **Set-value split.** The first write must land in both the comparator and the period, and a later write must reach only the period. A design that lets every periodic write move the comparator would shift the pulse train.
- **32-bit wrap.** A comparator near 2^32 plus a period whose top bit was cleared must produce a match whose next target wraps to 0x7FFFFFE0. Getting the forced bit or the wrap wrong leaves a different readback or fires a stray pulse.
- **Counter jumps ahead while disabled.** The comparator must stay put while disabled, then step past the counter without a pulse once enabled. An unconditioned catch-up would move early or fire spuriously.
- **All-ones comparator.** A comparator of all ones must stay parked. An unconditioned catch-up would move it.
- **Randomized checks.** Random periods and configuration words check the write mask and the pulse spacing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned BUS_W = 32;

    typedef enum logic [1:0] {
        ADR_CFG_LO = 2'd0,
        ADR_CFG_HI = 2'd1,
        ADR_CMP_LO = 2'd2,
        ADR_CMP_HI = 2'd3
    } tmr_addr_e;

    localparam int unsigned B_LVL  = 1;
    localparam int unsigned B_IEN  = 2;
    localparam int unsigned B_PER  = 3;
    localparam int unsigned B_PCAP = 4;
    localparam int unsigned B_SETV = 6;
    localparam int unsigned B_M32  = 8;
    localparam int unsigned RT_LSB = 9;
    localparam int unsigned RT_W   = 5;

    localparam logic [BUS_W-1:0] CFG_WR_MASK = 32'h0000_7F4E;
endpackage

// File: rtl/tmr_cmp_eval.sv
module tmr_cmp_eval #(
    parameter int unsigned CNT_W = 64
) (
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             m32_i,
    output logic             eq_o,
    output logic             later_o,
    output logic             ones_o
);
    localparam int unsigned HALF = CNT_W / 2;

    logic [CNT_W-1:0] diff;

    always_comb begin
        diff = cmp_i - cnt_i;
        if (m32_i) begin
            eq_o    = (cmp_i[HALF-1:0] == cnt_i[HALF-1:0]);
            later_o = !diff[HALF-1] && (diff[HALF-1:0] != '0);
            ones_o  = (cmp_i[HALF-1:0] == '1);
        end else begin
            eq_o    = (cmp_i == cnt_i);
            later_o = !diff[CNT_W-1] && (diff != '0);
            ones_o  = (cmp_i == '1);
        end
    end
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic [1:0]       addr_i,
    input  logic [BUS_W-1:0] cfg_i,
    input  logic [BUS_W-1:0] cap_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [BUS_W-1:0] rdata_o
);
    localparam int unsigned HALF = CNT_W / 2;

    always_comb begin
        unique case (tmr_addr_e'(addr_i))
            ADR_CFG_LO: rdata_o = cfg_i | (BUS_W'(1) << B_PCAP);
            ADR_CFG_HI: rdata_o = cap_i;
            ADR_CMP_LO: rdata_o = cmp_i[HALF-1:0];
            default:    rdata_o = cmp_i[CNT_W-1:HALF];
        endcase
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned      CNT_W  = 64,
    parameter logic [31:0]      CAP_HI = 32'h00FF_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      cnt_i,
    input  logic             glb_en_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    output logic             irq_o,
    output logic             stat_o,
    output logic [4:0]       route_o
);
    localparam int unsigned HALF = CNT_W / 2;

    typedef struct packed {
        logic [BUS_W-1:0] cfg;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] per;
        logic             irq;
        logic             stat;
    } chan_t;

    chan_t s_q, s_d;
    logic  eq, later, ones;
    logic  fire, advance;

    tmr_cmp_eval #(.CNT_W(CNT_W)) u_eval (
        .cmp_i   (s_q.cmp),
        .cnt_i   (cnt_i[CNT_W-1:0]),
        .m32_i   (s_q.cfg[B_M32]),
        .eq_o    (eq),
        .later_o (later),
        .ones_o  (ones)
    );

    tmr_rd_mux #(.CNT_W(CNT_W)) u_rd (
        .addr_i  (addr_i),
        .cfg_i   (s_q.cfg),
        .cap_i   (CAP_HI),
        .cmp_i   (s_q.cmp),
        .rdata_o (rdata_o)
    );

    always_comb begin
        logic [CNT_W-1:0] sum;
        logic             m32, perm, setv;
        s_d   = s_q;
        s_d.irq = 1'b0;
        m32   = s_q.cfg[B_M32];
        perm  = s_q.cfg[B_PER];
        setv  = s_q.cfg[B_SETV];
        fire    = glb_en_i && eq && s_q.cfg[B_IEN];
        advance = glb_en_i && perm && (s_q.per != '0) && !ones && !later;
        sum = s_q.cmp + s_q.per;
        if (m32) sum[CNT_W-1:HALF] = '0;
        if (fire) begin
            s_d.irq  = 1'b1;
            s_d.stat = 1'b1;
        end
        if (advance) s_d.cmp = sum;
        if (wr_en_i) begin
            unique case (tmr_addr_e'(addr_i))
                ADR_CFG_LO: begin
                    s_d.cfg = (s_q.cfg & ~CFG_WR_MASK) | (wdata_i & CFG_WR_MASK);
                    if (wdata_i[B_M32]) begin
                        s_d.cmp[CNT_W-1:HALF] = '0;
                        s_d.per[CNT_W-1:HALF] = '0;
                    end
                end
                ADR_CFG_HI: ;
                ADR_CMP_LO: begin
                    if (!perm || setv) s_d.cmp = {s_q.cmp[CNT_W-1:HALF], wdata_i};
                    if (perm) begin
                        s_d.per[HALF-1:0] = wdata_i;
                        if (m32) s_d.per[HALF-1] = 1'b0;
                    end
                    s_d.cfg[B_SETV] = 1'b0;
                end
                default: begin
                    if (!m32) begin
                        if (!perm || setv) s_d.cmp = {wdata_i, s_q.cmp[HALF-1:0]};
                        if (perm) s_d.per[CNT_W-1:HALF] = {1'b0, wdata_i[HALF-2:0]};
                    end
                    s_d.cfg[B_SETV] = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cfg  <= '0;
            s_q.cmp  <= '1;
            s_q.per  <= '0;
            s_q.irq  <= 1'b0;
            s_q.stat <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o   = s_q.irq;
    assign stat_o  = s_q.stat;
    assign route_o = s_q.cfg[RT_LSB +: RT_W];

    // R1: comparator parked at all ones right after reset
    a_r1_cmp_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (s_q.cmp == '1));
    // R7: a pulse only follows a cycle with both enables high
    a_r7_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(glb_en_i && s_q.cfg[B_IEN]));
    // R7: a pulse always comes with status set
    a_r7_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> stat_o);
    // R6: set-value gone after a comparator write
    a_r6_setv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i[1]) |=> !s_q.cfg[B_SETV]);
    // R5: period top bit never set
    a_r5_period_top: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.per[CNT_W-1]);
    // R9: upper halves stay clear in 32-bit mode
    a_r9_m32_upper: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cfg[B_M32] |-> (s_q.cmp[CNT_W-1:HALF] == '0 && s_q.per[CNT_W-1:HALF] == '0));
    // R10: comparator frozen without enable or write
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en_i && !wr_en_i) |=> $stable(s_q.cmp));
    // R2: upper config slot write leaves config alone
    a_r2_hi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 2'd1) |=> $stable(s_q.cfg));
endmodule

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CAP = 32'h00FF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt_i = '0;
    logic        glb_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o, stat_o;
    logic [4:0]  route_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    tmr_channel #(.CAP_HI(CAP)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .glb_en_i(glb_en_i),
        .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o), .stat_o(stat_o), .route_o(route_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    function automatic logic [63:0] eff(input logic [63:0] v, input bit m32);
        return m32 ? {32'h0, v[31:0]} : v;
    endfunction

    task automatic sweep(input logic [63:0] v0, input int n, input logic [63:0] c0,
                         input logic [63:0] p, input bit m32, input bit on, input string req,
                         output logic [63:0] last);
        logic [63:0] nxt = c0;
        for (int i = 0; i < n; i++) begin
            logic exp;
            cnt_i = v0 + 64'(i);
            @(negedge clk);
            exp = on && (eff(cnt_i, m32) == nxt);
            if (exp && p != 0) nxt = eff(nxt + p, m32);
            chk(req, irq_o, exp);
        end
        last = nxt;
    endtask

    initial begin
        logic [31:0] r, d;
        logic [63:0] last;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2, r); chk("R1 cmp lo", r, 32'hFFFF_FFFF);
        rd(3, r); chk("R1 cmp hi", r, 32'hFFFF_FFFF);
        rd(0, r); chk("R1 cfg", r, 32'h10);
        chk("R1 irq", irq_o, 0);
        chk("R1 stat", stat_o, 0);

        // R2 random config write mask, R3 route
        for (int i = 0; i < 20; i++) begin
            d = $urandom();
            wr(0, d);
            rd(0, r); chk("R2 cfg mask", r, (d & 32'h7F4E) | 32'h10);
            chk("R3 route", route_o, d[13:9]);
        end
        wr(0, 32'h0000_3A04);
        wr(1, 32'hDEAD_BEEF);
        rd(1, r); chk("R2 cap hi", r, CAP);
        rd(0, r); chk("R2 cfg kept", r, 32'h0000_3A14);
        chk("R3 route fixed", route_o, 5'h1D);

        // R4 one-shot random comparator writes
        wr(0, 32'h0);
        for (int i = 0; i < 10; i++) begin
            logic [31:0] lo, hi;
            lo = $urandom(); hi = $urandom();
            wr(2, lo); wr(3, hi);
            rd(2, r); chk("R4 oneshot lo", r, lo);
            rd(3, r); chk("R4 oneshot hi", r, hi);
        end

        // R7 one-shot pulse
        wr(0, 32'h4); wr(2, 100); wr(3, 0);
        glb_en_i = 1'b1;
        sweep(95, 12, 100, 0, 0, 1, "R7 oneshot", last);
        chk("R7 status", stat_o, 1);
        // R10 global enable low: no pulse
        glb_en_i = 1'b0;
        sweep(95, 12, 100, 0, 0, 0, "R10 no global", last);
        // R7 interrupt enable low: no pulse
        wr(0, 32'h0);
        glb_en_i = 1'b1;
        sweep(95, 12, 100, 0, 0, 0, "R7 no ien", last);
        glb_en_i = 1'b0;

        // R4 R5 R6 R8 periodic with set-value
        wr(0, 32'h4C); wr(2, 200);
        rd(0, r); chk("R6 setv cleared", r[6], 0);
        wr(3, 0); wr(2, 50);
        rd(2, r); chk("R4 periodic no setv", r, 200);
        glb_en_i = 1'b1;
        sweep(190, 131, 200, 50, 0, 1, "R8 periodic", last);
        glb_en_i = 1'b0;
        rd(2, r); chk("R8 final cmp", r, 32'd350);

        // R8 random periods
        for (int k = 0; k < 4; k++) begin
            logic [31:0] p, c;
            p = 3 + ($urandom() % 18);
            c = 100 + ($urandom() % 100);
            wr(0, 32'h4C); wr(2, c); wr(3, 0);
            wr(2, p);
            glb_en_i = 1'b1;
            sweep(64'(c) - 5, 100, 64'(c), 64'(p), 0, 1, "R8 random period", last);
            glb_en_i = 1'b0;
            rd(2, r); chk("R8 random cmp", r, last[31:0]);
        end

        // R5 R9 32-bit mode wrap and top bit force
        wr(0, 32'h14C); wr(2, 32'hFFFF_FFF0);
        glb_en_i = 1'b1;
        sweep(64'h1234_5678_FFFF_FFEC, 12, 64'hFFFF_FFF0, 64'h7FFF_FFF0, 1, 1, "R9 wrap", last);
        glb_en_i = 1'b0;
        rd(2, r); chk("R5 R9 wrapped cmp", r, 32'h7FFF_FFE0);
        rd(3, r); chk("R9 cmp hi zero", r, 0);

        // R9 truncation on mode select, high write ignored
        wr(0, 32'h0); wr(2, 32'h1111); wr(3, 32'hAB);
        wr(0, 32'h100);
        rd(3, r); chk("R9 truncate", r, 0);
        rd(2, r); chk("R9 low kept", r, 32'h1111);
        wr(3, 32'h55);
        rd(3, r); chk("R9 hi write ignored", r, 0);

        // R10 frozen while disabled, catch-up on enable
        wr(0, 32'h4C); wr(2, 1000); wr(3, 0); wr(2, 10);
        cnt_i = 1055;
        repeat (5) @(negedge clk);
        rd(2, r); chk("R10 frozen", r, 1000);
        glb_en_i = 1'b1;
        begin
            int pulses = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (irq_o) pulses++;
            end
            chk("R10 catch-up silent", pulses, 0);
        end
        rd(2, r); chk("R10 caught up", r, 1060);
        cnt_i = 1060;
        @(negedge clk);
        chk("R8 pulse after catch-up", irq_o, 1);
        glb_en_i = 1'b0;

        // R10 all-ones comparator stays parked
        wr(0, 32'h4C); wr(2, 32'hFFFF_FFFF);
        wr(0, 32'h4C); wr(3, 32'hFFFF_FFFF);
        cnt_i = 5;
        glb_en_i = 1'b1;
        repeat (6) @(negedge clk);
        rd(2, r); chk("R10 ones lo", r, 32'hFFFF_FFFF);
        rd(3, r); chk("R10 ones hi", r, 32'hFFFF_FFFF);
        glb_en_i = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule